// File: doc/BRIEF.md
# Clock Fanout Bank Output Controller

This block takes one internal clock and fans it out to two banks of five clock outputs and one feedback output. The source is either a VCO-rate clock or, in bypass, the reference clock. A two-bit range select post-divides the source by 1, 2, 4 or 8. The divided clock drives bank A and the feedback output. Bank B either copies bank A or runs at half its rate. When bank B runs at half rate, each bank B rising edge still falls on a bank A rising edge.

A stop request is brought into the source domain through a synchronizer. It is then taken up on the falling edge of each bank clock, so a bank is halted or released only while its outputs are low and no shortened pulse appears. A separate tristate request lowers the pad drive enable of both banks. Neither request touches the feedback output, so a loop that closes through it stays locked. Raising the tristate request and the bypass select together puts the whole block in reset.

Top module: `clk_fanout_ctrl`

## Requirements
- R1: While tri_en and bypass_sel are both 1, bank_a, bank_b and fb_out are all 0 and drv_en is 0; clocking resumes after both are released.
- R2: With bypass_sel = 0 the source is vco_clk; with bypass_sel = 1 the source is ref_clk.
- R3: range_sel values 0, 1, 2 and 3 make fb_out and bank A run at the source frequency divided by 1, 2, 4 and 8.
- R4: The five outputs of a bank always carry the same value.
- R5: With halve_b = 0 bank B matches the bank A frequency; with halve_b = 1 it runs at half of it, and every bank B rising edge coincides with a rising edge of fb_out.
- R6: stop_req = 1 holds both banks low once it has passed two source edges and the next falling edge of the bank clock; stop_req = 0 releases them with the same latency.
- R7: Every bank A high pulse begins and ends together with an fb_out high pulse (no runt pulses at stop or restart).
- R8: drv_en is 0 whenever tri_en is 1, whatever stop_req is, and 1 when tri_en is 0.
- R9: fb_out keeps toggling at its R3 rate whatever the values of stop_req and tri_en.
- R10: A change of range_sel during operation restarts the post-divider and the bank B halving stage, and bank B stays edge-aligned with bank A afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | VCO-rate clock, source in normal mode |
| ref_clk | input | 1 | Reference clock, source in bypass |
| bypass_sel | input | 1 | 1 selects ref_clk as the source |
| range_sel | input | 2 | Post-divide select: source divided by 2^range_sel |
| halve_b | input | 1 | 1 runs bank B at half the bank A rate |
| stop_req | input | 1 | 1 halts both banks in the low state |
| tri_en | input | 1 | 1 removes the pad drive of both banks |
| bank_a | output | 5 | Bank A clock outputs |
| bank_b | output | 5 | Bank B clock outputs |
| fb_out | output | 1 | Feedback clock, never stopped or tristated |
| drv_en | output | 1 | Pad drive enable for both banks |

## Verification
drv_en follows tri_en with no clock delay, and the reset state holds as soon as both reset inputs are high. The bench therefore samples these a few nanoseconds after it drives them. A stop or a restart appears after two source edges plus at most one bank-clock period, so the bench waits at least that long before it opens a counting window. Frequencies are checked by counting rising edges over a window that is a whole number of periods long after a settle time of four bank B periods, with a tolerance of one edge. Pulse boundaries and bank B alignment are checked one nanosecond after each output edge, against the level of fb_out.

// File: rtl/clk_fanout_pkg.sv
package clk_fanout_pkg;
   // largest range select width supported (divide by up to 2^(2^3-1))
   localparam int unsigned MAX_RANGE_W = 3;
   // fewest synchronizer stages accepted
   localparam int unsigned MIN_SYNC = 2;

   function automatic int unsigned div_of(input int unsigned sel);
      return 32'd1 << sel;
   endfunction
endpackage

// File: rtl/clk_src_sel.sv
module clk_src_sel
   import clk_fanout_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic vco_clk,
   input  logic ref_clk,
   input  logic bypass_sel,
   input  logic tri_en,
   input  logic stop_req,
   output logic src_clk,
   output logic rst_o,
   output logic stop_s
);
   logic rst_req;
   logic [SYNC_STAGES-1:0] rst_pipe;
   logic [SYNC_STAGES-1:0] stop_pipe;

   generate
      if (SYNC_STAGES < MIN_SYNC) begin : g_bad_sync
         $error("clk_src_sel: SYNC_STAGES below minimum");
      end
   endgenerate

   assign src_clk = bypass_sel ? ref_clk : vco_clk;
   assign rst_req = tri_en & bypass_sel;

   // reset: asserts at once, leaves after SYNC_STAGES source edges
   always_ff @(posedge src_clk or posedge rst_req) begin
      if (rst_req) rst_pipe <= '1;
      else         rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b0};
   end
   assign rst_o = rst_pipe[SYNC_STAGES-1];

   // stop request brought into the source domain
   always_ff @(posedge src_clk or posedge rst_o) begin
      if (rst_o) stop_pipe <= '0;
      else       stop_pipe <= {stop_pipe[SYNC_STAGES-2:0], stop_req};
   end
   assign stop_s = stop_pipe[SYNC_STAGES-1];

   assert_rst_hold_R1: assert property (@(posedge src_clk) rst_req |=> rst_o);

   assert_stop_sync_R6: assert property (@(posedge src_clk) disable iff (rst_o)
      $rose(stop_s) |-> $past(stop_req, SYNC_STAGES));
endmodule

// File: rtl/clk_postdiv.sv
module clk_postdiv
   import clk_fanout_pkg::*;
#(
   parameter int unsigned RANGE_W = 2
) (
   input  logic               src_clk,
   input  logic               rst,
   input  logic [RANGE_W-1:0] range_sel,
   input  logic               halve,
   output logic               base_clk,
   output logic               bclk
);
   localparam int unsigned NUM_RANGES = 1 << RANGE_W;
   localparam int unsigned CNT_W      = NUM_RANGES - 1;

   generate
      if (RANGE_W < 1 || RANGE_W > MAX_RANGE_W) begin : g_bad_range
         $error("clk_postdiv: RANGE_W out of bounds");
      end
   endgenerate

   logic [RANGE_W-1:0]    range_q;
   logic                  chg;
   logic [CNT_W-1:0]      cnt;
   logic [NUM_RANGES-1:0] taps;
   logic                  clr;
   logic                  tgl;

   always_ff @(posedge src_clk or posedge rst) begin
      if (rst) begin
         range_q <= '0;
         chg     <= 1'b0;
         cnt     <= '0;
      end else begin
         range_q <= range_sel;
         chg     <= (range_sel != range_q);
         cnt     <= (range_sel != range_q) ? '0 : cnt + CNT_W'(1);
      end
   end

   assign taps[0] = src_clk & ~rst;
   generate
      for (genvar k = 1; k < NUM_RANGES; k++) begin : g_tap
         assign taps[k] = cnt[k-1];
      end
   endgenerate

   assign base_clk = taps[range_q];
   assign clr      = rst | chg;

   // halving stage restarts with the divider
   always_ff @(posedge base_clk or posedge clr) begin
      if (clr) tgl <= 1'b0;
      else     tgl <= ~tgl;
   end

   assign bclk = halve ? tgl : base_clk;

   assert_b_edge_R5: assert property (@(posedge src_clk) disable iff (clr)
      (range_q != '0 && $rose(tgl)) |-> $rose(base_clk));

   assert_div2_R3: assert property (@(posedge src_clk) disable iff (clr)
      (range_q == RANGE_W'(1) && $past(range_q) == RANGE_W'(1)) |-> (base_clk != $past(base_clk)));
endmodule

// File: rtl/clk_stop_gate.sv
module clk_stop_gate #(
   parameter int unsigned N_OUT = 5
) (
   input  logic             src_clk,
   input  logic             clk_in,
   input  logic             rst,
   input  logic             stop_s,
   output logic [N_OUT-1:0] q
);
   generate
      if (N_OUT < 1) begin : g_bad_width
         $error("clk_stop_gate: N_OUT must be at least 1");
      end
   endgenerate

   logic run;
   logic gated;

   // enable moves only on the falling edge, while the clock is low
   always_ff @(negedge clk_in or posedge rst) begin
      if (rst) run <= 1'b0;
      else     run <= ~stop_s;
   end

   assign gated = clk_in & run;

   generate
      for (genvar i = 0; i < N_OUT; i++) begin : g_fan
         assign q[i] = gated;
      end
   endgenerate

   assert_gate_low_R7: assert property (@(posedge src_clk) disable iff (rst)
      (run != $past(run)) |-> !clk_in);
endmodule

// File: rtl/clk_fanout_ctrl.sv
module clk_fanout_ctrl #(
   parameter int unsigned N_OUT       = 5,
   parameter int unsigned RANGE_W     = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic               vco_clk,
   input  logic               ref_clk,
   input  logic               bypass_sel,
   input  logic [RANGE_W-1:0] range_sel,
   input  logic               halve_b,
   input  logic               stop_req,
   input  logic               tri_en,
   output logic [N_OUT-1:0]   bank_a,
   output logic [N_OUT-1:0]   bank_b,
   output logic               fb_out,
   output logic               drv_en
);
   logic src_clk;
   logic rst;
   logic stop_s;
   logic base_clk;
   logic bclk;

   clk_src_sel #(.SYNC_STAGES(SYNC_STAGES)) u_src (
      .vco_clk    (vco_clk),
      .ref_clk    (ref_clk),
      .bypass_sel (bypass_sel),
      .tri_en     (tri_en),
      .stop_req   (stop_req),
      .src_clk    (src_clk),
      .rst_o      (rst),
      .stop_s     (stop_s)
   );

   clk_postdiv #(.RANGE_W(RANGE_W)) u_div (
      .src_clk   (src_clk),
      .rst       (rst),
      .range_sel (range_sel),
      .halve     (halve_b),
      .base_clk  (base_clk),
      .bclk      (bclk)
   );

   clk_stop_gate #(.N_OUT(N_OUT)) u_gate_a (
      .src_clk (src_clk),
      .clk_in  (base_clk),
      .rst     (rst),
      .stop_s  (stop_s),
      .q       (bank_a)
   );

   clk_stop_gate #(.N_OUT(N_OUT)) u_gate_b (
      .src_clk (src_clk),
      .clk_in  (bclk),
      .rst     (rst),
      .stop_s  (stop_s),
      .q       (bank_b)
   );

   // feedback path bypasses both the stop gate and the drive enable
   assign fb_out = base_clk;
   assign drv_en = ~tri_en;
endmodule

// File: tb/sim_clk_fanout_ctrl.sv
module sim_clk_fanout_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int REF_PERIOD = 30;

   logic       vco_clk = 1'b0;
   logic       ref_clk = 1'b0;
   logic       bypass_sel = 1'b1;
   logic [1:0] range_sel = 2'd0;
   logic       halve_b = 1'b0;
   logic       stop_req = 1'b0;
   logic       tri_en = 1'b1;
   logic [4:0] bank_a, bank_b;
   logic       fb_out, drv_en;

   int n_tests = 0, n_fail = 0;
   int na = 0, nb = 0, nf = 0;
   int runt_err = 0, align_err = 0, eq_err = 0;
   bit mon_en = 1'b0;

   clk_fanout_ctrl u0 (
      .vco_clk(vco_clk), .ref_clk(ref_clk), .bypass_sel(bypass_sel),
      .range_sel(range_sel), .halve_b(halve_b), .stop_req(stop_req),
      .tri_en(tri_en), .bank_a(bank_a), .bank_b(bank_b),
      .fb_out(fb_out), .drv_en(drv_en)
   );

   always #(CLK_PERIOD/2) vco_clk = ~vco_clk;
   initial begin
      #1;
      forever #(REF_PERIOD/2) ref_clk = ~ref_clk;
   end

   always @(posedge bank_a[0]) begin
      na++;
      if (mon_en) begin #1; if (fb_out !== 1'b1) runt_err++; end
   end
   always @(negedge bank_a[0]) begin
      if (mon_en) begin #1; if (fb_out !== 1'b0) runt_err++; end
   end
   always @(posedge bank_b[0]) begin
      nb++;
      if (mon_en) begin #1; if (fb_out !== 1'b1) align_err++; end
   end
   always @(posedge fb_out) nf++;
   always @(posedge vco_clk) begin
      #2;
      if (mon_en && (bank_a !== {5{bank_a[0]}} || bank_b !== {5{bank_b[0]}})) eq_err++;
   end

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic bit near(input int a, input int e);
      return (a >= e - 1) && (a <= e + 1);
   endfunction

   function automatic int bank_b_period(input bit byp, input int rg, input bit hv);
      return (byp ? REF_PERIOD : CLK_PERIOD) * (1 << rg) * (hv ? 2 : 1);
   endfunction

   task automatic clear_counts();
      na = 0; nb = 0; nf = 0; runt_err = 0; align_err = 0; eq_err = 0;
   endtask

   task automatic apply_cfg(input bit byp, input int rg, input bit hv, input bit stp, input bit tr);
      mon_en = 1'b0;
      tri_en = 1'b1; bypass_sel = 1'b1;
      range_sel = rg[1:0]; halve_b = hv; stop_req = stp;
      #(REF_PERIOD * 4);
      bypass_sel = byp; tri_en = tr;
      #(4 * bank_b_period(byp, rg, hv) + 10 * REF_PERIOD);
   endtask

   // window fixed in vco terms so the source ratio shows in the counts
   task automatic run_window(input bit byp, input int rg, input bit hv, input bit stp, input bit tr);
      int m, t, p, ef, eb;
      m  = hv ? 2 : 1;
      t  = 48 * CLK_PERIOD * (1 << rg) * m;
      p  = byp ? REF_PERIOD : CLK_PERIOD;
      ef = t / (p * (1 << rg));
      eb = ef / m;
      clear_counts();
      mon_en = 1'b1;
      #(t);
      mon_en = 1'b0;
      chk(near(nf, ef), byp ? "R2" : "R3", "fb_out edges", nf, ef);
      chk(near(na, stp ? 0 : ef), stp ? "R6" : "R3", "bank_a edges", na, stp ? 0 : ef);
      chk(near(nb, stp ? 0 : eb), stp ? "R6" : "R5", "bank_b edges", nb, stp ? 0 : eb);
      chk(drv_en === !tr, "R8", "drv_en", int'(drv_en), int'(!tr));
      chk(runt_err == 0, "R7", "runt pulses", runt_err, 0);
      chk(align_err == 0, "R5", "bank_b misaligned edges", align_err, 0);
      chk(eq_err == 0, "R4", "bank bits differ", eq_err, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd2718));

      // R1: reset state
      #(REF_PERIOD * 6);
      clear_counts();
      #(REF_PERIOD * 10);
      chk(bank_a === 5'd0 && bank_b === 5'd0, "R1", "banks in reset", int'({bank_a, bank_b}), 0);
      chk(fb_out === 1'b0 && nf == 0, "R1", "fb edges in reset", nf, 0);
      chk(drv_en === 1'b0, "R1", "drv_en in reset", int'(drv_en), 0);

      // R1/R3: release and run at divide by one
      apply_cfg(1'b0, 0, 1'b0, 1'b0, 1'b0);
      run_window(1'b0, 0, 1'b0, 1'b0, 1'b0);

      // R6/R7/R9: stop and restart while running
      clear_counts();
      mon_en = 1'b1;
      #(CLK_PERIOD * 3 + 2);
      stop_req = 1'b1;
      #(CLK_PERIOD * 6);
      na = 0; nf = 0;
      #(CLK_PERIOD * 20);
      chk(na == 0, "R6", "bank_a edges while stopped", na, 0);
      chk(near(nf, 20), "R9", "fb_out edges while stopped", nf, 20);
      tri_en = 1'b1;
      #3;
      chk(drv_en === 1'b0, "R8", "drv_en with stop and tristate", int'(drv_en), 0);
      nf = 0;
      #(CLK_PERIOD * 20);
      chk(near(nf, 20), "R9", "fb_out edges while tristated", nf, 20);
      tri_en = 1'b0;
      stop_req = 1'b0;
      #(CLK_PERIOD * 6);
      na = 0;
      #(CLK_PERIOD * 20);
      chk(near(na, 20), "R6", "bank_a edges after restart", na, 20);
      mon_en = 1'b0;
      chk(runt_err == 0, "R7", "runt pulses around stop", runt_err, 0);

      // R10: live range change with halving
      apply_cfg(1'b0, 1, 1'b1, 1'b0, 1'b0);
      range_sel = 2'd2;
      #(CLK_PERIOD * 64);
      run_window(1'b0, 2, 1'b1, 1'b0, 1'b0);
      chk(align_err == 0, "R10", "alignment after range change", align_err, 0);

      // R2: bypass at divide by one
      apply_cfg(1'b1, 0, 1'b0, 1'b0, 1'b0);
      run_window(1'b1, 0, 1'b0, 1'b0, 1'b0);

      // constrained random configurations
      for (int i = 0; i < 12; i++) begin
         bit byp, hv, stp, tr;
         int rg;
         byp = ($urandom % 3) == 0;
         rg  = $urandom % 4;
         hv  = $urandom % 2;
         stp = ($urandom % 3) == 0;
         tr  = byp ? 1'b0 : (($urandom % 4) == 0);
         apply_cfg(byp, rg, hv, stp, tr);
         run_window(byp, rg, hv, stp, tr);
      end

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule